// File: doc/BRIEF.md
# Branch-and-Link Control Unit

This block is the program-counter control of a small processor core. In every clock cycle it receives one decoded 32-bit instruction word together with the two register-file operands that word selects. From these, the current program counter and the zero (Z) and carry (C) flags, it chooses the next program counter. For the linking forms it also produces a register-file write-back in the same cycle.

Supported control transfers:
- an absolute jump and a PC-relative jump;
- a swap-jump that deposits its return word in any register;
- a register-indirect jump that always deposits its return word in one fixed register;
- a call and a return that use a private four-entry return stack.

A return word carries the flags above the saved address. Per-instruction flag bits choose whether Z and C are saved into the return word. The same bits choose whether Z and C are reloaded when the jump target comes from a stored word. Instruction fetch and the general ALU sit outside this block. Instructions that are not branches simply advance the counter.

Top module: `bl_ctrl`

## Requirements
- R1: Synchronous active-high reset sets the counter to 0, both flags to 0, the stack to empty and the error flag to 0. An instruction that is not a branch (for example all zeros) advances the counter by 1 with no write-back.
- R2: Word fields are op[31:25], WZ[24], WC[23], I[22], cond[21:18], D[17:9] and S[8:0]; the 17-bit literal is word[16:0]. Opcode 1101100 jumps to the literal when I=0. When I=1 it jumps to counter+1+literal, modulo 2^17.
- R3: A branch is taken only when cond bit number {C,Z} is 1 (1111 = always, 0000 = never). A failed condition gives counter+1, with no write-back, no stack change and no flag change.
- R4: Swap-jump (opcode 1011111) writes the return word to register address D. Its target is S zero-extended when I=1, and the S operand bits [16:0] when I=0.
- R5: The return word has counter+1 in bits [16:0], Z AND WZ in bit 18, C AND WC in bit 17, and zeros elsewhere. It is built from the flags held before the instruction.
- R6: Opcode 1111111 with word[4:0]=01000 jumps to the D operand bits [16:0] and writes the return word to register address 0x1EF. With any other word[4:0] this opcode acts as a plain advance.
- R7: The register-form swap-jump, the indirect jump and the return reload Z from bit 18 of the source word when WZ=1, and C from bit 17 when WC=1. A flag whose bit is 0 keeps its value. The immediate swap-jump reloads nothing.
- R8: Call (opcode 1101101) pushes the return word and jumps as in R2. Return (opcode 1101110) pops and jumps to bits [16:0] of the popped word.
- R9: The stack is last-in first-out with 4 entries. A push onto a full stack discards the oldest entry and raises the error flag.
- R10: A pop from an empty stack returns the word in the deepest slot, which keeps its value as entries move up. It raises the error flag, and the error flag stays set until reset.
- R11: The write-back outputs are valid in the cycle that holds the instruction. The register write and the counter update happen on the same rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Decoded instruction word for this cycle |
| d_val | input | DATA_W | Register-file operand addressed by D |
| s_val | input | DATA_W | Register-file operand addressed by S |
| pc | output | PC_W | Current program counter (registered) |
| flag_z | output | 1 | Zero flag (registered) |
| flag_c | output | 1 | Carry flag (registered) |
| wb_en | output | 1 | Register write-back enable for this cycle |
| wb_addr | output | 9 | Register write-back address |
| wb_data | output | DATA_W | Register write-back data (return word) |
| stk_err | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
The checker assumes that a new instruction word and its operands are presented every cycle. It also assumes the operands already reflect the register file for that word's D and S fields, since the block never reads registers itself. The bench keeps to this assumption: it drives the word and both operands together just after a falling edge and holds them through the next rising edge. The bench places every flag-bearing operand so that the flag bits sit in positions 18 and 17 and bits above 18 are zero. In the same way, the stack bench issues calls and returns only as single words, so a push and a pop never fall in the same cycle.

// File: rtl/bl_pkg.sv
package bl_pkg;

  localparam logic [6:0] OP_JUMP = 7'b1101100;
  localparam logic [6:0] OP_CALL = 7'b1101101;
  localparam logic [6:0] OP_RET  = 7'b1101110;
  localparam logic [6:0] OP_SWAP = 7'b1011111;
  localparam logic [6:0] OP_LINK = 7'b1111111;
  localparam logic [4:0] LINK_SEL = 5'b01000;
  localparam logic [8:0] LINK_REG = 9'h1EF;

  typedef enum logic [2:0] {
    K_NONE, K_JUMP, K_CALL, K_RET, K_SWAP, K_LINK
  } kind_t;

  typedef struct packed {
    kind_t      kind;
    logic       wz;
    logic       wc;
    logic       imm;
    logic [3:0] cond;
    logic [8:0] dfield;
    logic [8:0] sfield;
  } dec_t;

  function automatic dec_t decode(input logic [31:0] w);
    dec_t d;
    d.wz     = w[24];
    d.wc     = w[23];
    d.imm    = w[22];
    d.cond   = w[21:18];
    d.dfield = w[17:9];
    d.sfield = w[8:0];
    case (w[31:25])
      OP_JUMP: d.kind = K_JUMP;
      OP_CALL: d.kind = K_CALL;
      OP_RET:  d.kind = K_RET;
      OP_SWAP: d.kind = K_SWAP;
      OP_LINK: d.kind = (w[4:0] == LINK_SEL) ? K_LINK : K_NONE;
      default: d.kind = K_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bl_cond.sv
module bl_cond (
  input  logic [3:0] cond,
  input  logic       z,
  input  logic       c,
  output logic       ok
);
  always_comb ok = cond[{c, z}];
endmodule

// File: rtl/bl_retstack.sv
module bl_retstack #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 19,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] push_word,
  output logic [WORD_W-1:0] top_word,
  output logic [CNT_W-1:0]  depth,
  output logic              err
);
  logic [WORD_W-1:0] slot     [DEPTH];
  logic [WORD_W-1:0] down_src [DEPTH];
  logic [WORD_W-1:0] up_src   [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_first
      assign down_src[i] = push_word;
    end else begin : g_rest
      assign down_src[i] = slot[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign up_src[i] = slot[i];
    end else begin : g_mid
      assign up_src[i] = slot[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)       slot[i] <= '0;
      else if (push) slot[i] <= down_src[i];
      else if (pop)  slot[i] <= up_src[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (push) begin
      if (cnt_q == CNT_W'(DEPTH)) err_q <= 1'b1;
      else                        cnt_q <= cnt_q + 1'b1;
    end else if (pop) begin
      if (cnt_q == '0) err_q <= 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_word = slot[0];
  assign depth    = cnt_q;
  assign err      = err_q;
endmodule

// File: rtl/bl_target.sv
module bl_target
  import bl_pkg::*;
#(
  parameter int PC_W   = 17,
  parameter int DATA_W = 32,
  localparam int WORD_W = PC_W + 2
) (
  input  kind_t             kind,
  input  logic              wz,
  input  logic              wc,
  input  logic              imm,
  input  logic [8:0]        dfield,
  input  logic [8:0]        sfield,
  input  logic [PC_W-1:0]   lit,
  input  logic              cond_ok,
  input  logic [PC_W-1:0]   pc,
  input  logic              z,
  input  logic              c,
  input  logic [DATA_W-1:0] d_val,
  input  logic [DATA_W-1:0] s_val,
  input  logic [WORD_W-1:0] top_word,
  output logic [PC_W-1:0]   next_pc,
  output logic              wb_en,
  output logic [8:0]        wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              push,
  output logic              pop,
  output logic              ld_z,
  output logic              ld_c,
  output logic              new_z,
  output logic              new_c
);
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   hop;
  logic [DATA_W-1:0] link_word;
  logic              unused_hi;

  assign unused_hi = ^{d_val[DATA_W-1:WORD_W], s_val[DATA_W-1:WORD_W]};

  always_comb begin
    pc_inc    = pc + 1'b1;
    hop       = imm ? PC_W'(pc_inc + lit) : lit;
    link_word = '0;
    link_word[PC_W-1:0] = pc_inc;
    link_word[PC_W+1]   = z & wz;
    link_word[PC_W]     = c & wc;

    next_pc = pc_inc;
    wb_en   = 1'b0;
    wb_addr = dfield;
    wb_data = link_word;
    push    = 1'b0;
    pop     = 1'b0;
    ld_z    = 1'b0;
    ld_c    = 1'b0;
    new_z   = z;
    new_c   = c;

    if (cond_ok) begin
      case (kind)
        K_JUMP: next_pc = hop;
        K_CALL: begin
          next_pc = hop;
          push    = 1'b1;
        end
        K_RET: begin
          next_pc = top_word[PC_W-1:0];
          pop     = 1'b1;
          ld_z    = wz;
          ld_c    = wc;
          new_z   = top_word[PC_W+1];
          new_c   = top_word[PC_W];
        end
        K_SWAP: begin
          wb_en = 1'b1;
          if (imm) begin
            next_pc = {{(PC_W-9){1'b0}}, sfield};
          end else begin
            next_pc = s_val[PC_W-1:0];
            ld_z    = wz;
            ld_c    = wc;
            new_z   = s_val[PC_W+1];
            new_c   = s_val[PC_W];
          end
        end
        K_LINK: begin
          wb_en   = 1'b1;
          wb_addr = LINK_REG;
          next_pc = d_val[PC_W-1:0];
          ld_z    = wz;
          ld_c    = wc;
          new_z   = d_val[PC_W+1];
          new_c   = d_val[PC_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bl_ctrl.sv
module bl_ctrl
  import bl_pkg::*;
#(
  parameter int PC_W        = 17,
  parameter int DATA_W      = 32,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] d_val,
  input  logic [DATA_W-1:0] s_val,
  output logic [PC_W-1:0]   pc,
  output logic              flag_z,
  output logic              flag_c,
  output logic              wb_en,
  output logic [8:0]        wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              stk_err
);
  localparam int WORD_W = PC_W + 2;
  localparam int CNT_W  = $clog2(STACK_DEPTH + 1);

  dec_t              dec;
  logic              cond_ok;
  logic [PC_W-1:0]   next_pc;
  logic              wb_raw, push_raw, pop_raw;
  logic              stk_push, stk_pop;
  logic              ld_z, ld_c, new_z, new_c;
  logic [WORD_W-1:0] top_word;
  logic [CNT_W-1:0]  stk_depth;
  logic [PC_W-1:0]   pc_q;
  logic              z_q, c_q;

  assign dec = decode(instr);

  bl_cond cond_i (
    .cond (dec.cond),
    .z    (z_q),
    .c    (c_q),
    .ok   (cond_ok)
  );

  bl_target #(.PC_W(PC_W), .DATA_W(DATA_W)) target_i (
    .kind     (dec.kind),
    .wz       (dec.wz),
    .wc       (dec.wc),
    .imm      (dec.imm),
    .dfield   (dec.dfield),
    .sfield   (dec.sfield),
    .lit      (instr[PC_W-1:0]),
    .cond_ok  (cond_ok),
    .pc       (pc_q),
    .z        (z_q),
    .c        (c_q),
    .d_val    (d_val),
    .s_val    (s_val),
    .top_word (top_word),
    .next_pc  (next_pc),
    .wb_en    (wb_raw),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .push     (push_raw),
    .pop      (pop_raw),
    .ld_z     (ld_z),
    .ld_c     (ld_c),
    .new_z    (new_z),
    .new_c    (new_c)
  );

  assign stk_push = push_raw & ~rst;
  assign stk_pop  = pop_raw & ~rst;
  assign wb_en    = wb_raw & ~rst;

  bl_retstack #(.DEPTH(STACK_DEPTH), .WORD_W(WORD_W)) stack_i (
    .clk       (clk),
    .rst       (rst),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_word (wb_data[WORD_W-1:0]),
    .top_word  (top_word),
    .depth     (stk_depth),
    .err       (stk_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      z_q  <= 1'b0;
      c_q  <= 1'b0;
    end else begin
      pc_q <= next_pc;
      if (ld_z) z_q <= new_z;
      if (ld_c) c_q <= new_c;
    end
  end

  assign pc     = pc_q;
  assign flag_z = z_q;
  assign flag_c = c_q;
endmodule

// File: rtl/bl_ctrl_chk.sv
module bl_ctrl_chk #(
  parameter int PC_W        = 17,
  parameter int DATA_W      = 32,
  parameter int STACK_DEPTH = 4,
  localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [6:0]        op,
  input logic [PC_W-1:0]   pc,
  input logic              flag_z,
  input logic              flag_c,
  input logic              wb_en,
  input logic [8:0]        wb_addr,
  input logic [DATA_W-1:0] wb_data,
  input logic              stk_err,
  input logic              cond_ok,
  input logic              push,
  input logic [CNT_W-1:0]  depth
);
  logic unused_flags;
  assign unused_flags = ^wb_data[PC_W+1:PC_W];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc == '0 && !flag_z && !flag_c && !stk_err)); // R1

  AST_FAIL_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |=> (pc == PC_W'($past(pc) + 1'b1))); // R3

  AST_FAIL_NO_WB: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |-> !wb_en); // R3

  AST_FAIL_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |=> (flag_z == $past(flag_z) && flag_c == $past(flag_c))); // R3

  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wb_en && op == 7'b1111111) |-> (wb_addr == 9'h1EF)); // R6

  AST_RET_WORD: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_data[PC_W-1:0] == PC_W'(pc + 1'b1) &&
               wb_data[DATA_W-1:PC_W+2] == '0)); // R5

  AST_FULL_PUSH_ERR: assert property (@(posedge clk) disable iff (rst)
    (push && depth == CNT_W'(STACK_DEPTH)) |=> stk_err); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    stk_err |=> stk_err); // R10

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(STACK_DEPTH)); // R9
endmodule

bind bl_ctrl bl_ctrl_chk #(
  .PC_W(PC_W), .DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .op      (instr[31:25]),
  .pc      (pc),
  .flag_z  (flag_z),
  .flag_c  (flag_c),
  .wb_en   (wb_en),
  .wb_addr (wb_addr),
  .wb_data (wb_data),
  .stk_err (stk_err),
  .cond_ok (cond_ok),
  .push    (stk_push),
  .depth   (stk_depth)
);

// File: tb/bl_ctrl_tb_top.sv
`timescale 1ns/1ps
module bl_ctrl_tb_top;
  localparam logic [6:0] JMP  = 7'b1101100;
  localparam logic [6:0] CALL = 7'b1101101;
  localparam logic [6:0] RET  = 7'b1101110;
  localparam logic [6:0] SWAP = 7'b1011111;
  localparam logic [6:0] LINK = 7'b1111111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] d_val = '0;
  logic [31:0] s_val = '0;
  logic [16:0] pc;
  logic        flag_z, flag_c, wb_en, stk_err;
  logic [8:0]  wb_addr;
  logic [31:0] wb_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  bl_ctrl dut_i (
    .clk(clk), .rst(rst), .instr(instr), .d_val(d_val), .s_val(s_val),
    .pc(pc), .flag_z(flag_z), .flag_c(flag_c), .wb_en(wb_en),
    .wb_addr(wb_addr), .wb_data(wb_data), .stk_err(stk_err)
  );

  function automatic logic [31:0] mk(input logic [6:0] op, input logic wz, input logic wc,
                                     input logic i, input logic [3:0] cnd, input logic [17:0] fld);
    return {op, wz, wc, i, cnd, fld};
  endfunction

  function automatic logic [31:0] rword(input logic z, input logic c, input logic [16:0] p);
    return {13'b0, z, c, p};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(input logic [31:0] w, input logic [31:0] dv, input logic [31:0] sv,
                      input bit exp_en, input logic [8:0] exp_a, input logic [31:0] exp_d,
                      input logic [16:0] exp_pc, input string tag);
    instr = w; d_val = dv; s_val = sv;
    #1;
    check(wb_en == exp_en, {tag, " wb_en R11"}, {31'b0, wb_en}, {31'b0, exp_en});
    if (exp_en) begin
      check(wb_addr == exp_a, {tag, " wb_addr"}, {23'b0, wb_addr}, {23'b0, exp_a});
      check(wb_data == exp_d, {tag, " wb_data R5"}, wb_data, exp_d);
    end
    @(posedge clk); #1;
    check(pc == exp_pc, {tag, " pc"}, {15'b0, pc}, {15'b0, exp_pc});
    @(negedge clk);
    instr = '0; d_val = '0; s_val = '0;
  endtask

  task automatic flags(input logic z, input logic c, input string tag);
    check(flag_z == z && flag_c == c, {tag, " flags"}, {30'b0, flag_z, flag_c}, {30'b0, z, c});
  endtask

  task automatic err_is(input logic e, input string tag);
    check(stk_err == e, {tag, " stk_err"}, {31'b0, stk_err}, {31'b0, e});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; instr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    check(pc == 17'h0, "R1 reset pc", {15'b0, pc}, 32'h0);
    flags(1'b0, 1'b0, "R1 reset");
    err_is(1'b0, "R1 reset");
    step(32'h0, '0, '0, 0, '0, '0, 17'h1, "R1 nop");
  endtask

  task automatic t_jumps();
    step(mk(JMP, 0, 0, 0, 4'hF, {1'b0, 17'h12345}), '0, '0, 0, '0, '0, 17'h12345, "R2 abs");
    step(mk(JMP, 0, 0, 1, 4'hF, {1'b0, 17'h00010}), '0, '0, 0, '0, '0, 17'h12356, "R2 rel");
    step(mk(JMP, 0, 0, 0, 4'hF, {1'b0, 17'h1FFFE}), '0, '0, 0, '0, '0, 17'h1FFFE, "R2 abs top");
    step(mk(JMP, 0, 0, 1, 4'hF, {1'b0, 17'h1FFFF}), '0, '0, 0, '0, '0, 17'h1FFFE, "R2 rel minus one");
    step(mk(JMP, 0, 0, 1, 4'hF, {1'b0, 17'h00005}), '0, '0, 0, '0, '0, 17'h00004, "R2 rel wrap");
  endtask

  task automatic t_cond();
    step(mk(JMP, 0, 0, 0, 4'b1110, {1'b0, 17'h777}), '0, '0, 0, '0, '0, 17'h5, "R3 fail z0c0");
    step(mk(JMP, 0, 0, 0, 4'b0001, {1'b0, 17'h100}), '0, '0, 0, '0, '0, 17'h100, "R3 pass z0c0");
    step(mk(SWAP, 1, 1, 1, 4'b1110, {9'h033, 9'h1A5}), '0, '0, 0, '0, '0, 17'h101, "R3 swap fail");
    flags(1'b0, 1'b0, "R3 swap fail");
  endtask

  task automatic t_swap();
    step(mk(SWAP, 0, 0, 1, 4'hF, {9'h033, 9'h1A5}), '0, '0, 1, 9'h033,
         rword(0, 0, 17'h102), 17'h1A5, "R4 swap imm");
    step(mk(SWAP, 1, 1, 0, 4'hF, {9'h040, 9'h011}), '0, rword(1, 1, 17'h0ABCD), 1, 9'h040,
         rword(0, 0, 17'h1A6), 17'h0ABCD, "R4 swap reg");
    flags(1'b1, 1'b1, "R7 swap reg restore");
    step(mk(SWAP, 1, 0, 1, 4'hF, {9'h041, 9'h0F0}), '0, rword(0, 0, 17'h0), 1, 9'h041,
         rword(1, 0, 17'h0ABCE), 17'h0F0, "R5 swap imm saves z only");
    flags(1'b1, 1'b1, "R7 imm no restore");
    step(mk(JMP, 0, 0, 0, 4'b0111, {1'b0, 17'h500}), '0, '0, 0, '0, '0, 17'h0F1, "R3 fail z1c1");
  endtask

  task automatic t_link();
    step(mk(LINK, 1, 1, 0, 4'hF, {9'h010, 9'h008}), rword(0, 0, 17'h12000), '0, 1, 9'h1EF,
         rword(1, 1, 17'h0F2), 17'h12000, "R6 link");
    flags(1'b0, 1'b0, "R7 link restore");
    step(mk(LINK, 1, 1, 0, 4'hF, {9'h010, 9'h009}), rword(1, 1, 17'h0AAAA), '0, 0, '0, '0,
         17'h12001, "R6 wrong select");
    flags(1'b0, 1'b0, "R6 wrong select");
    step(mk(LINK, 0, 1, 0, 4'hF, {9'h010, 9'h008}), rword(1, 1, 17'h200), '0, 1, 9'h1EF,
         rword(0, 0, 17'h12002), 17'h200, "R7 link wc only");
    flags(1'b0, 1'b1, "R7 partial restore");
  endtask

  task automatic t_stack();
    // z=0, c=1 on entry, pc=0x200
    step(mk(CALL, 0, 1, 0, 4'hF, {1'b0, 17'h300}), '0, '0, 0, '0, '0, 17'h300, "R8 call1");
    step(mk(CALL, 0, 0, 1, 4'hF, {1'b0, 17'h0FF}), '0, '0, 0, '0, '0, 17'h400, "R8 call rel");
    step(mk(CALL, 0, 0, 0, 4'hF, {1'b0, 17'h500}), '0, '0, 0, '0, '0, 17'h500, "R8 call3");
    step(mk(CALL, 0, 0, 0, 4'hF, {1'b0, 17'h600}), '0, '0, 0, '0, '0, 17'h600, "R8 call4");
    err_is(1'b0, "R9 four pushes");
    step(mk(CALL, 0, 0, 0, 4'hF, {1'b0, 17'h700}), '0, '0, 0, '0, '0, 17'h700, "R9 call5");
    err_is(1'b1, "R9 overflow");
    step(mk(RET, 0, 0, 0, 4'hF, 18'h0), '0, '0, 0, '0, '0, 17'h601, "R9 pop1");
    step(mk(RET, 0, 0, 0, 4'hF, 18'h0), '0, '0, 0, '0, '0, 17'h501, "R9 pop2");
    step(mk(RET, 0, 0, 0, 4'hF, 18'h0), '0, '0, 0, '0, '0, 17'h401, "R9 pop3");
    step(mk(RET, 0, 0, 0, 4'hF, 18'h0), '0, '0, 0, '0, '0, 17'h301, "R9 pop4 oldest dropped");
    step(mk(RET, 0, 0, 0, 4'hF, 18'h0), '0, '0, 0, '0, '0, 17'h301, "R10 empty pop");
    step(32'h0, '0, '0, 0, '0, '0, 17'h302, "R10 nop");
    err_is(1'b1, "R10 sticky");
    flags(1'b0, 1'b1, "R8 ret no restore");
  endtask

  task automatic t_ret_flags();
    do_reset();
    check(pc == 17'h0, "R1 re-reset pc", {15'b0, pc}, 32'h0);
    err_is(1'b0, "R1 re-reset");
    step(mk(SWAP, 1, 1, 0, 4'hF, {9'h001, 9'h002}), '0, rword(1, 0, 17'h050), 1, 9'h001,
         rword(0, 0, 17'h1), 17'h050, "R7 set z");
    flags(1'b1, 1'b0, "R7 set z");
    step(mk(CALL, 1, 1, 0, 4'hF, {1'b0, 17'h080}), '0, '0, 0, '0, '0, 17'h080, "R8 call flags");
    step(mk(LINK, 1, 1, 0, 4'hF, {9'h003, 9'h008}), rword(0, 1, 17'h090), '0, 1, 9'h1EF,
         rword(1, 0, 17'h081), 17'h090, "R6 link swap flags");
    flags(1'b0, 1'b1, "R7 link flags");
    step(mk(RET, 1, 1, 0, 4'hF, 18'h0), '0, '0, 0, '0, '0, 17'h051, "R8 ret");
    flags(1'b1, 1'b0, "R7 ret restore");
    err_is(1'b0, "R9 balanced");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_jumps();
    t_cond();
    t_swap();
    t_link();
    t_stack();
    t_ret_flags();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule